// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable model of a byte-wide serial EEPROM that sits on a two-wire bus as a slave. It watches the serial clock and data lines through synchronisers. It detects Start and Stop conditions and decodes a device select byte. That byte carries the fixed type code `1010`, three chip-enable bits compared with strap inputs, and a read/write flag. It then carries out byte writes, sequential writes, random reads and current-address reads against an internal byte array. The block drives SDA only by pulling it low (open drain).

A 16-bit address counter steps after every data byte and wraps from 0xFFFF to 0x0000. The array holds `2**MEM_AW` bytes and is indexed by the low counter bits, so with `MEM_AW = 16` it is the full 64K x 8 array. A write-lock input blocks data bytes. A Stop that ends a write with stored data starts an internal write cycle of `WRITE_CYCLES` clocks. During that cycle the device refuses its select byte, so a master can poll for completion. A power-good input gates the whole protocol: while it is low, the device is deaf and SDA is released.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0) and stays released while the bus is idle.
- R2: The device acknowledges a select byte only when its bits 7..4 equal 1010 and its bits 3..1 equal `chip_sel[2:0]`. On a mismatch it gives no acknowledge and ignores every byte until the next Start.
- R3: After a select byte with bit 0 = 0 (write), the next two bytes are taken as the memory address, high byte first, and each is acknowledged.
- R4: Each data byte written is stored at the counter address and acknowledged in the ninth clock, and the counter then steps by one. Consecutive bytes land at consecutive addresses.
- R5: The address counter wraps from 0xFFFF to 0x0000, for both writes and reads.
- R6: While `wr_lock` is 1, data bytes are not acknowledged and the array is unchanged, and no write cycle starts. Select and address bytes are still acknowledged.
- R7: A repeated Start after the address phase, followed by a select byte with bit 0 = 1, returns bytes MSB first, starting at the loaded address. The device continues while the master acknowledges and releases SDA after a master no-acknowledge.
- R8: A read with no address phase starts at the current counter value, which is one past the last byte written or read.
- R9: A Stop that ends a write with at least one stored byte starts a write cycle of `WRITE_CYCLES` clocks. During that cycle the select byte is not acknowledged; after it, the select byte is acknowledged again.
- R10: While `por_ok` is 0, SDA is released and all bus activity is ignored. Dropping `por_ok` aborts a command in progress and stores nothing.
- R11: The device changes its SDA drive only while the synchronised SCL is low, so read data stays stable during each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| por_ok | input | 1 | Power-good enable; 0 holds the protocol idle |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| chip_sel | input | 3 | Strap value matched against select bits 3..1 |
| wr_lock | input | 1 | 1 blocks storage of data bytes |

## Verification
A wrong protocol state shows first at the ack slot. The master sees a missing or extra acknowledge at the ninth clock of the byte where the state went wrong, so the bench checks the acknowledge on every byte it sends. A wrong address counter does not show during the write. It shows only on the next read, as data from the wrong location, so each write is read back through a random read and then a current-address read. A wrong write-cycle counter shows on a select poll: an acknowledge that comes too early or never comes, within one select byte of the Stop.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int         CNT_W    = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA
  } proto_st_t;

  // Next counter value: 16-bit step with natural wrap at 0xFFFF.
  function automatic logic [CNT_W-1:0] addr_next(input logic [CNT_W-1:0] a);
    return a + 16'd1;
  endfunction

  // Select byte matches type code and strap bits.
  function automatic logic sel_match(input logic [7:0] b, input logic [2:0] strap);
    return (b[7:4] == DEV_TYPE) && (b[3:1] == strap);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s && !scl_q;
  assign scl_fall = !scl_s && scl_q;
  assign start_ev = scl_s && scl_q && sda_q && !sda_s;
  assign stop_ev  = scl_s && scl_q && !sda_q && sda_s;

endmodule

// File: rtl/eeprom_mem.sv
module eeprom_mem #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];

endmodule

// File: rtl/eeprom_proto.sv
module eeprom_proto
  import eeprom_pkg::*;
#(
  parameter int MEM_AW       = 11,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_ok,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [2:0]        chip_sel,
  input  logic              wr_lock,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_idx,
  output logic [7:0]        mem_wdata,
  output logic              sda_oe
);

  localparam int BW = $clog2(WRITE_CYCLES + 1);

  proto_st_t        st;
  logic [3:0]       bit_cnt;
  logic             ack_ph;
  logic [7:0]       rx_sh;
  logic [7:0]       tx_sh;
  logic [CNT_W-1:0] addr;
  logic [7:0]       addr_hi;
  logic             acked;
  logic             mack;
  logic             wrote;
  logic [BW-1:0]    busy_cnt;

  // Named internal events
  logic busy;
  logic rx_bit;
  logic ack_enter;
  logic ack_exit;
  logic tx_step;
  logic sel_ok;

  assign busy      = (busy_cnt != '0);
  assign rx_bit    = scl_rise && !ack_ph && (bit_cnt < 4'd8) && (st != ST_IDLE);
  assign ack_enter = scl_fall && !ack_ph && (bit_cnt == 4'd8) && (st != ST_IDLE);
  assign ack_exit  = scl_fall && ack_ph;
  assign tx_step   = scl_fall && !ack_ph && (st == ST_RDATA) &&
                     (bit_cnt != 4'd0) && (bit_cnt < 4'd8);
  assign sel_ok    = sel_match(rx_sh, chip_sel) && !busy;

  assign mem_we    = por_ok && ack_enter && (st == ST_WDATA) && !wr_lock;
  assign mem_idx   = addr[MEM_AW-1:0];
  assign mem_wdata = rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n || !por_ok) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      ack_ph   <= 1'b0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      addr     <= '0;
      addr_hi  <= '0;
      acked    <= 1'b0;
      mack     <= 1'b0;
      wrote    <= 1'b0;
      busy_cnt <= '0;
      sda_oe   <= 1'b0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (start_ev) begin
        st      <= ST_DEVSEL;
        bit_cnt <= '0;
        ack_ph  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_ev) begin
        st      <= ST_IDLE;
        bit_cnt <= '0;
        ack_ph  <= 1'b0;
        sda_oe  <= 1'b0;
        if (wrote) begin
          busy_cnt <= BW'(WRITE_CYCLES);
          wrote    <= 1'b0;
        end
      end else begin
        if (rx_bit) begin
          rx_sh   <= {rx_sh[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end
        if (ack_ph && scl_rise) mack <= !sda_s;
        if (tx_step) begin
          sda_oe <= !tx_sh[6];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end
        if (ack_enter) begin
          ack_ph <= 1'b1;
          unique case (st)
            ST_DEVSEL: begin
              acked  <= sel_ok;
              sda_oe <= sel_ok;
            end
            ST_AHI: begin
              addr_hi <= rx_sh;
              sda_oe  <= 1'b1;
            end
            ST_ALO: begin
              addr   <= {addr_hi, rx_sh};
              sda_oe <= 1'b1;
            end
            ST_WDATA: begin
              sda_oe <= !wr_lock;
              if (!wr_lock) begin
                addr  <= addr_next(addr);
                wrote <= 1'b1;
              end
            end
            default: sda_oe <= 1'b0;
          endcase
        end
        if (ack_exit) begin
          ack_ph  <= 1'b0;
          bit_cnt <= '0;
          sda_oe  <= 1'b0;
          unique case (st)
            ST_DEVSEL: begin
              if (!acked) begin
                st <= ST_IDLE;
              end else if (rx_sh[0]) begin
                st     <= ST_RDATA;
                tx_sh  <= mem_rdata;
                sda_oe <= !mem_rdata[7];
                addr   <= addr_next(addr);
              end else begin
                st <= ST_AHI;
              end
            end
            ST_AHI: st <= ST_ALO;
            ST_ALO: st <= ST_WDATA;
            ST_RDATA: begin
              if (mack) begin
                tx_sh  <= mem_rdata;
                sda_oe <= !mem_rdata[7];
                addr   <= addr_next(addr);
              end else begin
                st <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R10: power-good low releases the line on the next cycle
  p_release_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> !sda_oe);

  // R11: drive changes happen only while synchronised SCL is low
  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (por_ok && $past(por_ok) && !$stable(sda_oe)) |-> !scl_s);

  // R9: a write cycle begins only right after a Stop
  p_busy_at_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));

  // R9: no select acknowledge while the write cycle runs
  p_poll_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_enter && (st == ST_DEVSEL) && busy) |=> !sda_oe);

  // R4 / R5: each stored byte advances the counter by one, wrapping
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr == addr_next($past(addr))));

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int MEM_AW       = 11,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] chip_sel,
  input  logic       wr_lock
);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              start_g, stop_g;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_idx;
  logic [7:0]        mem_wdata, mem_rdata;

  assign start_g = start_ev && por_ok;
  assign stop_g  = stop_ev && por_ok;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  eeprom_proto #(.MEM_AW(MEM_AW), .WRITE_CYCLES(WRITE_CYCLES)) u_proto (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_ok    (por_ok),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_g),
    .stop_ev   (stop_g),
    .chip_sel  (chip_sel),
    .wr_lock   (wr_lock),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_idx   (mem_idx),
    .mem_wdata (mem_wdata),
    .sda_oe    (sda_oe)
  );

  eeprom_mem #(.AW(MEM_AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .idx   (mem_idx),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

endmodule

// File: tb/tb_serial_eeprom_slave.sv
`timescale 1ns/1ps
module tb_serial_eeprom_slave;

  localparam int WRC = 1000;
  localparam int Q   = 10;
  localparam logic [2:0] CS = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_ok = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wr_lock = 1'b0;
  logic sda_oe;
  logic sda_line;
  int   n_tests = 0;
  int   n_fail = 0;
  int   stable_err = 0;
  logic [7:0] rbuf [4];

  assign sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  serial_eeprom_slave #(.WRITE_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .chip_sel(CS), .wr_lock(wr_lock)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      if (sda_line != b[i]) stable_err++;
      scl = 1'b0;
    end
    tick(Q);
    sda_m = !give_ack; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic select_addr(input logic [15:0] a, output bit ok);
    bit k1, k2, k3;
    bus_start;
    send_byte({4'hA, CS, 1'b0}, k1);
    send_byte(a[15:8], k2);
    send_byte(a[7:0], k3);
    ok = k1 && k2 && k3;
  endtask

  task automatic write_seq(input logic [15:0] a, input int n, input logic [7:0] d0,
                           input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3,
                           output bit ok);
    bit k;
    logic [7:0] d [4];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    select_addr(a, ok);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], k);
      ok = ok && k;
    end
    bus_stop;
    tick(WRC + 50);
  endtask

  task automatic read_cont(input int n, output bit ok);
    bus_start;
    send_byte({4'hA, CS, 1'b1}, ok);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop;
  endtask

  task automatic random_read(input logic [15:0] a, input int n, output bit ok);
    bit k1, k2;
    select_addr(a, k1);
    read_cont(n, k2);
    ok = k1 && k2;
  endtask

  task automatic t_reset;
    check(sda_oe == 1'b0, "R1 sda released after reset", int'(sda_oe), 0);
    tick(50);
    check(sda_oe == 1'b0, "R1 sda released on idle bus", int'(sda_oe), 0);
  endtask

  task automatic t_mismatch;
    bit k;
    bus_start; send_byte({4'hB, CS, 1'b0}, k); bus_stop;
    check(!k, "R2 wrong type code acked", int'(k), 0);
    bus_start; send_byte({4'hA, 3'b001, 1'b0}, k);
    check(!k, "R2 wrong chip bits acked", int'(k), 0);
    send_byte(8'h00, k);
    check(!k, "R2 byte after mismatch acked", int'(k), 0);
    bus_stop;
  endtask

  task automatic t_write_read;
    bit ok;
    write_seq(16'h0120, 4, 8'h11, 8'h22, 8'h33, 8'h44, ok);
    check(ok, "R3 R4 select/address/data acks", int'(ok), 1);
    stable_err = 0;
    random_read(16'h0120, 3, ok);
    check(ok, "R7 random read acks", int'(ok), 1);
    check(rbuf[0] == 8'h11, "R7 R4 byte 0", rbuf[0], 8'h11);
    check(rbuf[1] == 8'h22, "R4 byte 1", rbuf[1], 8'h22);
    check(rbuf[2] == 8'h33, "R4 byte 2", rbuf[2], 8'h33);
    check(stable_err == 0, "R11 data stable while SCL high", stable_err, 0);
    check(sda_oe == 1'b0, "R7 released after master nack", int'(sda_oe), 0);
    read_cont(1, ok);
    check(ok && rbuf[0] == 8'h44, "R8 current-address read", rbuf[0], 8'h44);
  endtask

  task automatic t_wrap;
    bit ok;
    write_seq(16'hFFFF, 2, 8'hAA, 8'hBB, 8'h00, 8'h00, ok);
    check(ok, "R5 write across wrap acked", int'(ok), 1);
    random_read(16'hFFFF, 2, ok);
    check(rbuf[0] == 8'hAA && rbuf[1] == 8'hBB, "R5 read across wrap",
          {rbuf[0], rbuf[1]}, 16'hAABB);
    random_read(16'h0000, 1, ok);
    check(rbuf[0] == 8'hBB, "R5 wrapped byte at 0x0000", rbuf[0], 8'hBB);
  endtask

  task automatic t_lock;
    bit ok, k;
    write_seq(16'h0400, 1, 8'h77, 8'h00, 8'h00, 8'h00, ok);
    wr_lock = 1'b1;
    select_addr(16'h0400, ok);
    check(ok, "R6 select/address acked while locked", int'(ok), 1);
    send_byte(8'h11, k);
    check(!k, "R6 data acked while locked", int'(k), 0);
    bus_stop;
    wr_lock = 1'b0;
    random_read(16'h0400, 1, ok);
    check(ok, "R6 no write cycle after locked write", int'(ok), 1);
    check(rbuf[0] == 8'h77, "R6 array unchanged", rbuf[0], 8'h77);
  endtask

  task automatic t_busy;
    bit ok, k;
    select_addr(16'h0200, ok);
    send_byte(8'h5A, k);
    bus_stop;
    bus_start; send_byte({4'hA, CS, 1'b0}, k); bus_stop;
    check(!k, "R9 select acked during write cycle", int'(k), 0);
    tick(WRC + 50);
    bus_start; send_byte({4'hA, CS, 1'b0}, k); bus_stop;
    check(k, "R9 select refused after write cycle", int'(k), 1);
    random_read(16'h0200, 1, ok);
    check(rbuf[0] == 8'h5A, "R9 byte stored", rbuf[0], 8'h5A);
  endtask

  task automatic t_power;
    bit ok, k;
    write_seq(16'h0300, 1, 8'h33, 8'h00, 8'h00, 8'h00, ok);
    por_ok = 1'b0;
    bus_start; send_byte({4'hA, CS, 1'b0}, k); bus_stop;
    check(!k, "R10 acked while power low", int'(k), 0);
    por_ok = 1'b1;
    select_addr(16'h0300, ok);
    por_ok = 1'b0;
    send_byte(8'hCC, k);
    check(!k && sda_oe == 1'b0, "R10 abort released line", int'(sda_oe), 0);
    bus_stop;
    por_ok = 1'b1;
    tick(20);
    random_read(16'h0300, 1, ok);
    check(ok && rbuf[0] == 8'h33, "R10 aborted write stored nothing", rbuf[0], 8'h33);
  endtask

  initial begin
    tick(10);
    rst_n = 1'b1;
    tick(10);
    t_reset;
    t_mismatch;
    t_write_read;
    t_wrap;
    t_lock;
    t_busy;
    t_power;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule